// File: doc/BRIEF.md
# Push-Button Press Detector

This block turns a raw, bouncing, active-low push-button line into one clean enable pulse in the system clock domain. It does not sample the button on every clock. A free-running divider raises a sample tick once every `TICK_COUNT` clocks. Only on that tick does the button level move into a short history register. That register acts as a synchronizer and as a time-domain filter against contact bounce.

A press is recognised when the history shows a released sample followed by pressed samples. The qualifying condition is combined with the tick, so the registered output is high for a single fast clock. Downstream counters use it as a clock enable. A parameter picks between a short filter and a long filter. The short filter needs one pressed sample behind the synchronizer stage. The long filter needs two successive pressed samples. With the default interval of a few million clocks, each sample is milliseconds apart. A tap briefer than one interval may go unseen, and this is accepted.

Top module: `btn_press_pulse`

## Requirements
- R1: Synchronous reset (`rst` high) clears the divider and loads every history stage with the released level (`btn_n` = 1 means released, 0 means pressed). `press_pulse` is 0 during reset and stays 0 afterwards while the button rests released.
- R2: The sample tick is high for exactly one clock in every `TICK_COUNT` clocks. The first tick falls in the `TICK_COUNT`-th clock after reset is released. `press_pulse` can only be high in the clock right after a tick.
- R3: `press_pulse` is never high for two consecutive clocks.
- R4: A press held for many sample intervals yields exactly one pulse in each filter mode.
- R5: After a pulse, no further pulse occurs until a released sample has entered the history. A release that ends before the next tick does not re-arm the detector.
- R6: A press that starts and ends between two ticks, without covering a tick, has no effect on `press_pulse`.
- R7: Short mode (`LONG_FILTER` = 0) uses three stages, with stage 0 nearest the pin. It fires when stage 2 is released and stage 1 is pressed on a tick. A press applied just after a tick and held gives a pulse exactly 3 × `TICK_COUNT` clocks later. A press covering only one tick still fires.
- R8: Long mode (`LONG_FILTER` = 1) uses four stages. It fires when stage 3 is released and stages 2 and 1 are both pressed on a tick. A held press gives a pulse 4 × `TICK_COUNT` clocks after it starts. A press covering only one tick gives no pulse.
- R9: Under arbitrary bouncing input, the output is exactly the sampled-history rule of R7 and R8 applied to the pin level seen at each tick.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| btn_n | input | 1 | Raw button level, 0 = pressed, asynchronous |
| press_pulse | output | 1 | One-clock enable per detected press |

## Verification
The bench aligns presses to the tick phase. It holds a press just short of one interval, which a design sampling every clock would wrongly report. It holds a press over exactly one tick, which separates the two filter depths: a long filter that fired here would have lost a stage. A button held for many intervals must give one pulse only. A level detector would repeat it, and a design that re-armed on an unsampled release would fire twice. Bursts of bounce are compared clock by clock against a history model. Pulse latency, width and phase are measured, which exposes an extra or missing register or a wrong terminal count.

// File: rtl/btn_pkg.sv
package btn_pkg;
    localparam logic LVL_RELEASED = 1'b1;
    localparam logic LVL_PRESSED  = 1'b0;
    localparam int   BASE_STAGES  = 3;

    function automatic int stage_count(input bit long_filter);
        return long_filter ? BASE_STAGES + 1 : BASE_STAGES;
    endfunction
endpackage

// File: rtl/btn_tick_gen.sv
module btn_tick_gen #(
    parameter int TICK_COUNT = 4_000_000
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    localparam int CNT_W = (TICK_COUNT > 2) ? $clog2(TICK_COUNT) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(TICK_COUNT - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } div_st_t;

    div_st_t s_d, s_q;

    always_comb begin
        s_d  = s_q;
        tick = (s_q.cnt == LAST);
        if (tick) begin
            s_d.cnt = '0;
        end else begin
            s_d.cnt = s_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end
endmodule

// File: rtl/btn_sample_chain.sv
module btn_sample_chain
    import btn_pkg::*;
#(
    parameter int STAGES = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              btn_n,
    output logic [STAGES-1:0] hist
);
    typedef struct packed {
        logic [STAGES-1:0] sh;
    } chain_st_t;

    chain_st_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (tick) begin
            s_d.sh = {s_q.sh[STAGES-2:0], btn_n};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s_q.sh <= {STAGES{LVL_RELEASED}};
        end else begin
            s_q <= s_d;
        end
    end

    assign hist = s_q.sh;
endmodule

// File: rtl/btn_edge_qual.sv
module btn_edge_qual
    import btn_pkg::*;
#(
    parameter int STAGES = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic [STAGES-1:0] hist,
    output logic              pulse
);
    localparam int MID_W = STAGES - 2;

    typedef struct packed {
        logic pulse;
    } qual_st_t;

    qual_st_t s_d, s_q;
    logic     older_released;
    logic     newer_pressed;

    always_comb begin
        older_released = (hist[STAGES-1] == LVL_RELEASED);
        newer_pressed  = (hist[STAGES-2:1] == {MID_W{LVL_PRESSED}});
        s_d            = s_q;
        s_d.pulse      = tick && older_released && newer_pressed;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign pulse = s_q.pulse;
endmodule

// File: rtl/btn_press_pulse.sv
module btn_press_pulse
    import btn_pkg::*;
#(
    parameter int TICK_COUNT  = 4_000_000,
    parameter bit LONG_FILTER = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic btn_n,
    output logic press_pulse
);
    localparam int STAGES = stage_count(LONG_FILTER);

    logic              tick;
    logic [STAGES-1:0] hist;

    btn_tick_gen #(.TICK_COUNT(TICK_COUNT)) u_tick (
        .clk  (clk),
        .rst  (rst),
        .tick (tick)
    );

    btn_sample_chain #(.STAGES(STAGES)) u_chain (
        .clk   (clk),
        .rst   (rst),
        .tick  (tick),
        .btn_n (btn_n),
        .hist  (hist)
    );

    btn_edge_qual #(.STAGES(STAGES)) u_qual (
        .clk   (clk),
        .rst   (rst),
        .tick  (tick),
        .hist  (hist),
        .pulse (press_pulse)
    );
endmodule

// File: rtl/btn_press_pulse_chk.sv
module btn_press_pulse_chk #(
    parameter int TICK_COUNT = 4_000_000,
    parameter int STAGES     = 3
) (
    input logic              clk,
    input logic              rst,
    input logic              tick,
    input logic [STAGES-1:0] hist,
    input logic              press_pulse
);
    localparam int CNT_W = (TICK_COUNT > 2) ? $clog2(TICK_COUNT) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(TICK_COUNT - 1);

    logic [CNT_W-1:0] gap_q;

    always_ff @(posedge clk) begin
        if (rst || tick) begin
            gap_q <= '0;
        end else begin
            gap_q <= gap_q + 1'b1;
        end
    end

    // R2: tick spacing measured by an independent counter
    a_r2_tick_period: assert property (@(posedge clk) disable iff (rst)
        tick |-> (gap_q == LAST));

    a_r2_tick_single: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick);

    a_r2_pulse_after_tick: assert property (@(posedge clk) disable iff (rst)
        press_pulse |-> $past(tick));

    a_r3_pulse_one_cycle: assert property (@(posedge clk) disable iff (rst)
        press_pulse |=> !press_pulse);

    // R5: once fired, the older stage already holds a pressed sample
    a_r5_rearm_needs_release: assert property (@(posedge clk) disable iff (rst)
        press_pulse |-> (hist[STAGES-1] == 1'b0));

    // R6: history moves only on a tick
    a_r6_hold_between_ticks: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(hist));
endmodule

bind btn_press_pulse btn_press_pulse_chk #(
    .TICK_COUNT (TICK_COUNT),
    .STAGES     (STAGES)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .tick        (tick),
    .hist        (hist),
    .press_pulse (press_pulse)
);

// File: tb/btn_press_pulse_tb.sv
module btn_press_pulse_tb;
    localparam int T = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic btn_n = 1'b1;
    logic p_s, p_l;

    always #2 clk = ~clk;

    btn_press_pulse #(.TICK_COUNT(T), .LONG_FILTER(1'b0)) u_dut (
        .clk(clk), .rst(rst), .btn_n(btn_n), .press_pulse(p_s));

    btn_press_pulse #(.TICK_COUNT(T), .LONG_FILTER(1'b1)) u_dut_long (
        .clk(clk), .rst(rst), .btn_n(btn_n), .press_pulse(p_l));

    // reference model built from R2, R7, R8
    int         cyc, mcnt;
    logic [2:0] hs;
    logic [3:0] hl;
    logic       es, el;

    always @(posedge clk) begin
        if (rst) begin
            cyc <= 0; mcnt <= 0; hs <= '1; hl <= '1; es <= 1'b0; el <= 1'b0;
        end else begin
            es <= (mcnt == T-1) && hs[2] && !hs[1];
            el <= (mcnt == T-1) && hl[3] && !hl[2] && !hl[1];
            if (mcnt == T-1) begin
                hs   <= {hs[1:0], btn_n};
                hl   <= {hl[2:0], btn_n};
                mcnt <= 0;
            end else begin
                mcnt <= mcnt + 1;
            end
            cyc <= cyc + 1;
        end
    end

    int n_chk = 0, n_fail = 0;
    int mis_s = 0, mis_l = 0, cnt_s = 0, cnt_l = 0, last_s = -1, last_l = -1;
    int width_err = 0, phase_err = 0;
    logic prev_s = 1'b0, prev_l = 1'b0;

    always @(negedge clk) begin
        if (!rst) begin
            if (p_s !== es) mis_s++;
            if (p_l !== el) mis_l++;
            if (p_s) begin cnt_s++; last_s = cyc; if (cyc % T != 0) phase_err++; end
            if (p_l) begin cnt_l++; last_l = cyc; if (cyc % T != 0) phase_err++; end
            if ((p_s && prev_s) || (p_l && prev_l)) width_err++;
            prev_s = p_s;
            prev_l = p_l;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic align();
        @(negedge clk);
        while (cyc % T != 0) @(negedge clk);
    endtask

    task automatic t_reset();
        rst = 1'b1; btn_n = 1'b1;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk(p_s == 1'b0 && p_l == 1'b0, "R1 pulse in reset", int'(p_s | p_l), 0);
        end
        rst = 1'b0;
        idle(10*T);
        chk(cnt_s == 0 && cnt_l == 0, "R1 idle after reset", cnt_s + cnt_l, 0);
    endtask

    task automatic t_hold();
        int c, bs, bl;
        align();
        c = cyc; bs = cnt_s; bl = cnt_l;
        btn_n = 1'b0;
        idle(10*T);
        chk(cnt_s - bs == 1, "R4 short held", cnt_s - bs, 1);
        chk(cnt_l - bl == 1, "R4 long held", cnt_l - bl, 1);
        chk(last_s == c + 3*T, "R7 latency", last_s - c, 3*T);
        chk(last_l == c + 4*T, "R8 latency", last_l - c, 4*T);
        btn_n = 1'b1;
        idle(6*T);
    endtask

    task automatic t_repress();
        int bs, bl;
        bs = cnt_s; bl = cnt_l;
        align();
        btn_n = 1'b0;
        idle(8*T);
        chk(cnt_s - bs == 1, "R5 rearm after release", cnt_s - bs, 1);
        // brief release that covers no tick
        bs = cnt_s; bl = cnt_l;
        align();
        btn_n = 1'b1;
        idle(T-2);
        btn_n = 1'b0;
        idle(8*T);
        chk(cnt_s - bs == 0 && cnt_l - bl == 0, "R5 unsampled release",
            (cnt_s - bs) + (cnt_l - bl), 0);
        btn_n = 1'b1;
        idle(6*T);
    endtask

    task automatic t_glitch();
        int bs, bl;
        bs = cnt_s; bl = cnt_l;
        align();
        btn_n = 1'b0;
        idle(T-2);
        btn_n = 1'b1;
        idle(8*T);
        chk(cnt_s - bs == 0 && cnt_l - bl == 0, "R6 press between ticks",
            (cnt_s - bs) + (cnt_l - bl), 0);
    endtask

    task automatic t_single_sample();
        int bs, bl;
        bs = cnt_s; bl = cnt_l;
        align();
        btn_n = 1'b0;
        idle(T);
        btn_n = 1'b1;
        idle(8*T);
        chk(cnt_s - bs == 1, "R7 one sample fires", cnt_s - bs, 1);
        chk(cnt_l - bl == 0, "R8 one sample ignored", cnt_l - bl, 0);
    endtask

    task automatic t_bounce();
        logic [7:0] lfsr = 8'hA5;
        for (int i = 0; i < 80; i++) begin
            lfsr  = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            btn_n = lfsr[0];
            idle(1 + (i % 5));
        end
        btn_n = 1'b0;
        idle(8*T);
        btn_n = 1'b1;
        idle(8*T);
        chk(mis_s == 0, "R9 short model match", mis_s, 0);
        chk(mis_l == 0, "R9 long model match", mis_l, 0);
        chk(phase_err == 0, "R2 pulse phase", phase_err, 0);
        chk(width_err == 0, "R3 pulse width", width_err, 0);
    endtask

    initial begin
        repeat (60000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_hold();
        t_repress();
        t_glitch();
        t_single_sample();
        t_bounce();
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule